// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master for extended (Clause 45) MDIO. It sits on a plain 32-bit register bus and drives the MDC clock and the MDIO data line towards external port devices. Software first loads a 16-bit register address into a dedicated register. It then writes a control word that carries the port address, the device address, the operation and, for writes, the payload.

That control write launches a two-frame sequence. The first frame sets the remote address pointer. The second frame either writes the payload or reads 16 bits back. A busy flag covers both frames. When a read finishes, the returned bits and a read-valid flag appear in the same control word.

The MDC rate is a fixed fraction of the system clock. A 2-bit field in a configuration register selects it. The remaining configuration bits are plain storage, so that software can do read-modify-write on them.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the control word (offset 0x0) and the configuration register (offset 0xC) read 0, MDC is low, and MDIO is driven high.
- R2: The control word reads back as data[15:0], port address[20:16], device address[25:21], operation[28:26], read-valid[29], busy[30] and bit 31 as 0. The register address lives in bits 15:0 at offset 0x8.
- R3: A write to offset 0x0 while idle starts a transaction, and busy reads 1 on the next cycle. Operation code 0x7 selects a read, and any other code (0x5 nominally) selects a write.
- R4: The first frame sent is 32 ones, start code 00, opcode 00, port address (5 bits, MSB first), device address (5 bits), turnaround 10, then the 16-bit register address MSB first.
- R5: For a write, the second frame is 32 ones, 00, opcode 01, port, device, turnaround 10, then the 16-bit payload MSB first.
- R6: For a read, the second frame is 32 ones, 00, opcode 11, port and device. MDIO is then released (output enable low) for bit positions 46 to 63 of the frame. The 16 bits sampled at positions 48 to 63, MSB first, land in data[15:0]. Read-valid is set when the bit sampled at position 47 is 0.
- R7: If the bit sampled at position 47 of a read frame is 1, read-valid stays 0.
- R8: Busy stays 1 across both frames, with MDC running continuously between them, for 128 MDC periods in total. Read-valid is 0 while busy.
- R9: A write to offset 0x0 while busy is ignored: the frames in flight and the stored fields are unchanged.
- R10: Configuration bits 1:0 select the MDC period in system clocks: 0 gives 256, 1 gives 64, 2 gives 32, 3 gives 8.
- R11: All 32 configuration bits read back as written.
- R12: While idle, MDC stays low and MDIO is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Internal faults in the frame engine show up at the pins within the same MDC period. A wrong shift-register load or bit index shows up as a wrong bit captured on an MDC rising edge, or as the output enable dropping at the wrong position. A faulty phase register shows up as a busy window that is not 128 MDC periods long, or as a read whose data or valid flag in the control word is wrong as soon as busy falls. Faults in the divider show up on the first MDC period, which the bench times against the selected ratio.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int ADR_W      = 5;
  localparam int DATA_W     = 16;
  localparam int TA_POS     = PRE_BITS + 4 + 2 * ADR_W;  // first turnaround bit
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DIV_C0     = 256;
  localparam int DIV_C1     = 64;
  localparam int DIV_C2     = 32;
  localparam int DIV_C3     = 8;
  localparam int CNT_W      = $clog2(DIV_C0 / 2);

  localparam logic [3:0] OFF_MGMT = 4'h0;
  localparam logic [3:0] OFF_RADR = 4'h8;
  localparam logic [3:0] OFF_CFG  = 4'hC;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;

  function automatic logic [CNT_W-1:0] half_of(input logic [1:0] sel);
    case (sel)
      2'd0:    half_of = CNT_W'(DIV_C0 / 2);
      2'd1:    half_of = CNT_W'(DIV_C1 / 2);
      2'd2:    half_of = CNT_W'(DIV_C2 / 2);
      default: half_of = CNT_W'(DIV_C3 / 2);
    endcase
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic [1:0] op, input logic [ADR_W-1:0] prt,
      input logic [ADR_W-1:0] dev, input logic [DATA_W-1:0] pay);
    build_frame = {{PRE_BITS{1'b1}}, 2'b00, op, prt, dev, 2'b10, pay};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_c45_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       mdc_o,
  output logic       rise_o,
  output logic       fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  // >= so a ratio change mid-flight cannot skip the terminal count
  assign tick   = en_i && (cnt_q >= half_of(sel_i) - CNT_W'(1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R10
  mdc_min_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_c45_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADR_W-1:0]  prt_i,
  input  logic [ADR_W-1:0]  dev_i,
  input  logic [DATA_W-1:0] regad_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ta_ok_o
);
  phase_e                  phase_q;
  logic [FRAME_BITS-1:0]   sh_q;
  logic [IDX_W-1:0]        idx_q;
  logic [DATA_W-1:0]       rsh_q, wd_q;
  logic [ADR_W-1:0]        prt_q, dev_q;
  logic                    rd_q, ta_q, done_q;
  logic                    released;

  assign released  = (phase_q == PH_DATA) && rd_q && (idx_q >= IDX_W'(TA_POS));
  assign busy_o    = (phase_q != PH_IDLE);
  assign mdio_o    = busy_o ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = !released;
  assign done_o    = done_q;
  assign rdata_o   = rsh_q;
  assign ta_ok_o   = ta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      rsh_q   <= '0;
      wd_q    <= '0;
      prt_q   <= '0;
      dev_q   <= '0;
      rd_q    <= 1'b0;
      ta_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && phase_q == PH_IDLE) begin
        phase_q <= PH_ADDR;
        sh_q    <= build_frame(2'b00, prt_i, dev_i, regad_i);
        idx_q   <= '0;
        prt_q   <= prt_i;
        dev_q   <= dev_i;
        rd_q    <= rd_i;
        wd_q    <= wdata_i;
        ta_q    <= 1'b0;
      end else if (fall_i && busy_o) begin
        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
          idx_q <= '0;
          if (phase_q == PH_ADDR) begin
            phase_q <= PH_DATA;
            sh_q    <= build_frame(rd_q ? 2'b11 : 2'b01, prt_q, dev_q,
                                   rd_q ? '1 : wd_q);
          end else begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end else begin
          idx_q <= idx_q + IDX_W'(1);
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end else if (rise_i && released) begin
        if (idx_q == IDX_W'(TA_POS + 1)) ta_q <= !mdio_i;
        else if (idx_q > IDX_W'(TA_POS + 1)) rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
      end
    end
  end

  // R8
  busy_ends_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(phase_q) == PH_DATA);
  // R6
  release_only_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !mdio_oe_o) |-> rd_q);
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic [DATA_W-1:0] data_q, regad_q, eng_rdata;
  logic [ADR_W-1:0]  prt_q, dev_q;
  logic [2:0]        op_q;
  logic              valid_q;
  logic [31:0]       cfg_q;
  logic              busy, start, mgmt_wr, done, ta_ok, rise, fall, rd_new;
  logic              unused_hi;

  assign mgmt_wr   = reg_we_i && (reg_addr_i == AW'(OFF_MGMT));
  assign start     = mgmt_wr && !busy;
  assign rd_new    = (reg_wdata_i[28:26] == 3'b111);
  assign unused_hi = ^reg_wdata_i[31:29];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      regad_q <= '0;
      prt_q   <= '0;
      dev_q   <= '0;
      op_q    <= '0;
      valid_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      if (start) begin
        data_q  <= reg_wdata_i[15:0];
        prt_q   <= reg_wdata_i[20:16];
        dev_q   <= reg_wdata_i[25:21];
        op_q    <= reg_wdata_i[28:26];
        valid_q <= 1'b0;
      end else if (done && op_q == 3'b111) begin
        data_q  <= eng_rdata;
        valid_q <= ta_ok;
      end
      if (reg_we_i && reg_addr_i == AW'(OFF_RADR)) regad_q <= reg_wdata_i[15:0];
      if (reg_we_i && reg_addr_i == AW'(OFF_CFG))  cfg_q   <= reg_wdata_i;
    end
  end

  always_comb begin
    case (reg_addr_i)
      AW'(OFF_MGMT): reg_rdata_o = {1'b0, busy, valid_q, op_q, dev_q, prt_q, data_q};
      AW'(OFF_RADR): reg_rdata_o = {16'h0, regad_q};
      AW'(OFF_CFG):  reg_rdata_o = cfg_q;
      default:       reg_rdata_o = '0;
    endcase
  end

  mdio_clk_div u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(busy), .sel_i(cfg_q[1:0]),
    .mdc_o (mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_engine u_eng (
    .clk_i  (clk_i), .rst_ni(rst_ni), .start_i(start), .rd_i(rd_new),
    .prt_i  (reg_wdata_i[20:16]), .dev_i(reg_wdata_i[25:21]),
    .regad_i(regad_q), .wdata_i(reg_wdata_i[15:0]),
    .rise_i (rise), .fall_i(fall), .mdio_i(mdio_i),
    .busy_o (busy), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .done_o (done), .rdata_o(eng_rdata), .ta_ok_o(ta_ok)
  );

  // R12
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && mdio_oe_o && mdio_o));
  // R9
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && mgmt_wr) |=> ($stable(prt_q) && $stable(op_q) && $stable(dev_q)));
  // R8
  valid_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !valid_q);
endmodule

// File: tb/sim_mdio_c45_master.sv
module sim_mdio_c45_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdo, moe, mdi;

  int vectors = 0, errors = 0, cyc = 0;

  // responder / monitor state
  logic        resp_q = 1'b1;
  bit          resp_rd, resp_ta;
  bit [15:0]   resp_val;
  int          rc = 0;
  bit          cap_b [128];
  bit          cap_oe[128];
  int          rise_t[2];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc++;

  assign mdi = moe ? mdo : resp_q;

  mdio_c45_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(moe), .mdio_i(mdi)
  );

  always @(posedge mdc) begin
    if (rc < 128) begin cap_b[rc] = mdo; cap_oe[rc] = moe; end
    if (rc < 2) rise_t[rc] = cyc;
    rc++;
  end

  always @(negedge mdc) begin
    int b;
    b = rc - 64;
    if (resp_rd && b == 47)                resp_q <= resp_ta;
    else if (resp_rd && b >= 48 && b < 64) resp_q <= resp_val[63 - b];
    else                                   resp_q <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic bit [63:0] frm(input bit [1:0] op, input bit [4:0] p,
                                    input bit [4:0] dv, input bit [15:0] pay);
    return {32'hFFFF_FFFF, 2'b00, op, p, dv, 2'b10, pay};
  endfunction

  task automatic txn(input bit [4:0] p, input bit [4:0] dv, input bit [15:0] ra,
                     input bit [15:0] wd, input bit is_rd, input bit ta,
                     input bit [15:0] rv, input int per, input bit inject);
    int busy_cyc, bad;
    bit [63:0] f1, f2;
    logic [31:0] r;
    resp_rd = is_rd; resp_ta = ta; resp_val = rv; rc = 0;
    wr(4'h8, {16'h0, ra});
    wr(4'h0, {3'b000, is_rd ? 3'b111 : 3'b101, dv, p, wd});
    #1 check("R3 busy after start", {31'h0, rdata[30]}, 32'h1);
    busy_cyc = 0;
    forever begin
      @(negedge clk);
      if (inject && busy_cyc == 100) begin
        we = 1'b1; addr = 4'h0; wdata = 32'h1FFF_FFFF;
      end else begin
        we = 1'b0; addr = 4'h0;
      end
      #1;
      if (!rdata[30]) break;
      if (rdata[29]) begin errors++; vectors++;
        $display("FAIL R8 valid while busy actual=1 expected=0"); end
      busy_cyc++;
      if (busy_cyc > 70000) begin errors++; vectors++;
        $display("FAIL R8 busy stuck actual=%0d expected=%0d", busy_cyc, 128*per); break; end
    end
    vectors++;
    if (busy_cyc < 128*per - 2 || busy_cyc > 128*per + 3) begin
      errors++; $display("FAIL R8 busy cycles actual=%0d expected=%0d", busy_cyc, 128*per);
    end
    check("R12 idle pins", {29'h0, mdc, moe, mdo}, 32'h3);
    check("R10 mdc period", rise_t[1] - rise_t[0], per);
    check("R8 rise count", rc, 128);
    f1 = frm(2'b00, p, dv, ra);
    f2 = frm(is_rd ? 2'b11 : 2'b01, p, dv, wd);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (cap_b[i] != f1[63-i] || !cap_oe[i]) bad++;
    check("R4 address frame bits", bad, 0);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      if (is_rd && i >= 46) begin if (cap_oe[64+i]) bad++; end
      else if (cap_b[64+i] != f2[63-i] || !cap_oe[64+i]) bad++;
    end
    check(is_rd ? "R6 read frame bits" : "R5 write frame bits", bad, 0);
    rd(4'h0, r);
    check("R2 R3 R6 R7 R9 control word", r,
          {1'b0, 1'b0, is_rd && !ta, is_rd ? 3'b111 : 3'b101, dv, p, is_rd ? rv : wd});
    resp_rd = 0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, r); check("R1 control reset", r, 32'h0);
    rd(4'hC, r); check("R1 config reset", r, 32'h0);
    check("R1 R12 pins at reset", {29'h0, mdc, moe, mdo}, 32'h3);
    wr(4'hC, 32'hABCD_0003);
    rd(4'hC, r); check("R11 config readback", r, 32'hABCD_0003);
    wr(4'h8, 32'h0000_1234);
    rd(4'h8, r); check("R2 register address readback", r, 32'h0000_1234);
    txn(5'h11, 5'h1E, 16'hC001, 16'h5A96, 0, 0, 0, 8, 0);
    txn(5'h03, 5'h07, 16'h8000, 16'h0000, 1, 0, 16'hA5C3, 8, 0);
    txn(5'h1F, 5'h01, 16'h0001, 16'h0000, 1, 1, 16'hFFFF, 8, 0);
    txn(5'h0A, 5'h15, 16'h7FFE, 16'h1357, 0, 0, 0, 8, 1);
    wr(4'hC, 32'hABCD_0002);
    txn(5'h01, 5'h02, 16'h00FF, 16'hFF00, 0, 0, 0, 32, 0);
    wr(4'hC, 32'h0000_0001);
    txn(5'h04, 5'h08, 16'h3C3C, 16'h0000, 1, 0, 16'h0001, 64, 0);
    wr(4'hC, 32'h0000_0000);
    txn(5'h10, 5'h10, 16'hFFFF, 16'h8001, 0, 0, 0, 256, 0);
    rd(4'hC, r); check("R11 config after use", r, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors++; vectors++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule